// File: doc/BRIEF.md
# Selectable-Source Baud Tick Generator

This block produces the two timing strobes that a serial port needs: a sampling strobe at the oversampling rate and a bit strobe at the line rate. Each strobe is high for one system-clock cycle. The block first picks a source strobe from one of three places: every system clock, the system clock slowed by a fixed prescale factor, or rising edges of an external clock pin that is first brought into the system clock domain. A programmable 16-bit divisor then divides this source strobe to form the sampling strobe.

In asynchronous operation, a post-divider of 8 or 16 turns the sampling strobe into the bit strobe. The oversampling select picks the factor. In synchronous operation, the post-divider is skipped and the bit strobe equals the sampling strobe.

Software loads a new divisor by pulsing a write strobe. That pulse restarts every counter in the chain from a known phase, and no strobe fires while it is high. The resulting line rate is the selected clock divided by the product of the divisor and either 8 or 16.

Top module: `baud_tick_gen`

## Requirements
- R1: A divisor of 0 stops the generator: `samp_tick` and `bit_tick` stay low.
- R2: A divisor of 1 bypasses the divider: `samp_tick` pulses on every source strobe.
- R3: A divisor D greater than 1 gives one `samp_tick` per D source strobes. After a write, the first one comes on the D-th source strobe.
- R4: In asynchronous mode (`sync_mode`=0) with `over`=0, `bit_tick` fires once per 16 `samp_tick` pulses, on the 16th.
- R5: In asynchronous mode with `over`=1, `bit_tick` fires once per 8 `samp_tick` pulses, on the 8th.
- R6: With `sync_mode`=1, `bit_tick` equals `samp_tick` in every cycle.
- R7: `src_sel` code 0 (2'b00) uses every system clock cycle as a source strobe. The reserved code 2 (2'b10) behaves exactly like code 0.
- R8: `src_sel` code 1 (2'b01) gives one source strobe per PRE_DIV system clocks (default 8). After a write, the first strobe comes on the PRE_DIV-th cycle.
- R9: `src_sel` code 3 (2'b11) passes `ext_clk` through a two-flop synchronizer. It gives exactly one source strobe per rising edge of `ext_clk`, provided each high and low phase of `ext_clk` lasts at least 5 system clocks.
- R10: A cycle with `div_wr` high shows no strobe on either output. It restarts the prescaler, the divider and the post-divider, so that counting starts again from the next cycle.
- R11: While `rst_n` is low, and in the first cycle after it is released, both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source select: 0 internal, 1 prescaled, 2 reserved (internal), 3 external pin |
| divisor | input | 16 | Divisor value; 0 stops the generator, 1 bypasses the divider |
| div_wr | input | 1 | One-cycle strobe marking a divisor write; restarts all counters |
| over | input | 1 | Oversampling select: 0 gives /16, 1 gives /8 in asynchronous mode |
| sync_mode | input | 1 | 1 selects synchronous mode, in which the post-divider is skipped |
| ext_clk | input | 1 | External clock pin (asynchronous to clk) |
| samp_tick | output | 1 | One-cycle sampling strobe |
| bit_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
A divisor write and a terminal count of the divider can land in the same cycle. The write must win: that cycle shows no strobe, and the next sampling strobe comes a full period later. The bench provokes this by reissuing the write in the exact cycle where a strobe is due after a previous write. It then checks for silence in that cycle and for the first strobe D-1 cycles later. Every swept configuration also opens with a write and judges both the write cycle and the position of the first strobe. The strobe counts over a long window must match the quotients computed from the divisor, the prescale factor and the post-divide ratio.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_PRE = 2'd1,
    SRC_RSV = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  localparam int unsigned POST_W = 4;

  // oversampling ratio as a count limit (ratio - 1)
  function automatic logic [POST_W-1:0] post_last(input logic over);
    return over ? POST_W'(7) : POST_W'(15);
  endfunction

  // divider terminal test: true once count has reached divisor - 1
  function automatic logic div_last(input logic [15:0] cnt, input logic [15:0] dv);
    return (dv > 16'd1) && (cnt >= (dv - 16'd1));
  endfunction

endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
  import baud_pkg::*;
#(
  parameter int unsigned PRE_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] src_sel,
  input  logic       ext_clk,
  output logic       src_tick,
  output logic       ext_sync
);

  logic pre_tick;
  logic ext_meta, ext_s2, ext_s3;
  logic ext_rise;

  generate
    if (PRE_DIV <= 1) begin : g_no_pre
      assign pre_tick = 1'b1;
    end else begin : g_pre
      localparam int unsigned PRE_W = $clog2(PRE_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
      logic [PRE_W-1:0] pre_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_cnt <= '0;
        else if (restart)           pre_cnt <= '0;
        else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
        else                        pre_cnt <= pre_cnt + 1'b1;
      end
      assign pre_tick = (pre_cnt == PRE_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_meta <= 1'b0;
      ext_s2   <= 1'b0;
      ext_s3   <= 1'b0;
    end else begin
      ext_meta <= ext_clk;
      ext_s2   <= ext_meta;
      ext_s3   <= ext_s2;
    end
  end

  assign ext_rise = ext_s2 & ~ext_s3;
  assign ext_sync = ext_s2;

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_PRE: src_tick = pre_tick;
      SRC_EXT: src_tick = ext_rise;
      default: src_tick = 1'b1;
    endcase
  end

endmodule

// File: rtl/baud_div.sv
module baud_div
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  input  logic             src_tick,
  output logic             samp_raw
);

  logic [DIV_W-1:0] cnt;
  logic             at_last;
  logic             bypass;

  assign bypass  = (divisor == DIV_W'(1));
  assign at_last = div_last(16'(cnt), 16'(divisor));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (restart)                   cnt <= '0;
    else if (divisor <= DIV_W'(1))      cnt <= '0;
    else if (src_tick)                  cnt <= at_last ? '0 : cnt + 1'b1;
  end

  assign samp_raw = src_tick & (bypass | at_last);

endmodule

// File: rtl/baud_post.sv
module baud_post
  import baud_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic over,
  input  logic sync_mode,
  input  logic samp_tick,
  output logic bit_raw
);

  logic [POST_W-1:0] pcnt;
  logic              term;

  assign term = (pcnt >= post_last(over));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pcnt <= '0;
    else if (restart || sync_mode) pcnt <= '0;
    else if (samp_tick)         pcnt <= term ? '0 : pcnt + 1'b1;
  end

  assign bit_raw = sync_mode ? samp_tick : (samp_tick & term);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             div_wr,
  input  logic             over,
  input  logic             sync_mode,
  input  logic             ext_clk,
  output logic             samp_tick,
  output logic             bit_tick
);

  logic run_q;
  logic src_tick;
  logic ext_sync;
  logic samp_raw;
  logic bit_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  baud_src_sel #(.PRE_DIV(PRE_DIV)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (div_wr),
    .src_sel  (src_sel),
    .ext_clk  (ext_clk),
    .src_tick (src_tick),
    .ext_sync (ext_sync)
  );

  baud_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (div_wr),
    .divisor  (divisor),
    .src_tick (src_tick),
    .samp_raw (samp_raw)
  );

  assign samp_tick = samp_raw & run_q & ~div_wr;

  baud_post u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (div_wr),
    .over      (over),
    .sync_mode (sync_mode),
    .samp_tick (samp_tick),
    .bit_raw   (bit_raw)
  );

  assign bit_tick = bit_raw;

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       src_sel,
  input logic [DIV_W-1:0] divisor,
  input logic             div_wr,
  input logic             sync_mode,
  input logic             src_tick,
  input logic             ext_sync,
  input logic             samp_tick,
  input logic             bit_tick
);

  // R1
  a_r1_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> (!samp_tick && !bit_tick));

  // R2
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == DIV_W'(1) && !div_wr && $past(rst_n)) |-> (samp_tick == src_tick));

  // R3: a sampling strobe needs a source strobe underneath it
  a_r3_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |-> src_tick);

  // R4 / R5: a bit strobe only rides on a sampling strobe
  a_r4_bit_on_samp: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> samp_tick);

  // R6
  a_r6_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> (bit_tick == samp_tick));

  // R9
  a_r9_ext_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3 && src_tick) |-> (ext_sync && !$past(ext_sync)));

  // R10
  a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |-> (!samp_tick && !bit_tick));

  // R11
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r11_reset_quiet: assert (!samp_tick && !bit_tick);
    end
  end

endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_sel   (src_sel),
  .divisor   (divisor),
  .div_wr    (div_wr),
  .sync_mode (sync_mode),
  .src_tick  (src_tick),
  .ext_sync  (ext_sync),
  .samp_tick (samp_tick),
  .bit_tick  (bit_tick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  localparam int PRE = 8;
  localparam int WIN = 720;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [15:0] divisor = 16'd1;
  logic        div_wr = 1'b0;
  logic        over = 1'b0;
  logic        sync_mode = 1'b0;
  logic        ext_clk = 1'b0;
  logic        samp_tick, bit_tick;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  baud_tick_gen #(.DIV_W(16), .PRE_DIV(PRE)) i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .divisor(divisor),
    .div_wr(div_wr), .over(over), .sync_mode(sync_mode), .ext_clk(ext_clk),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue a divisor write and check the write cycle is silent
  task automatic do_write(input logic [1:0] s, input int d, input logic ov, input logic sy);
    @(negedge clk);
    src_sel = s; divisor = 16'(d); over = ov; sync_mode = sy; div_wr = 1'b1;
    #1;
    chk("R10 write cycle silent", int'(samp_tick) + int'(bit_tick), 0);
  endtask

  task automatic run_cfg(input logic [1:0] s, input int d, input logic ov, input logic sy);
    int base, ratio, ns, nb, first, exp_s, exp_b, exp_first;
    string rq;
    base  = (s == 2'd1) ? PRE : 1;
    ratio = ov ? 8 : 16;
    ns = 0; nb = 0; first = -1;
    do_write(s, d, ov, sy);
    for (int j = 0; j < WIN; j++) begin
      @(negedge clk);
      div_wr = 1'b0;
      #1;
      if (samp_tick) begin
        if (first < 0) first = j;
        ns++;
      end
      if (bit_tick) nb++;
    end
    exp_s     = (d == 0) ? 0 : WIN / (base * d);
    exp_b     = (d == 0) ? 0 : (sy ? exp_s : WIN / (base * d * ratio));
    exp_first = (d == 0) ? -1 : base * d - 1;
    rq = (d == 0) ? "R1" : (d == 1) ? "R2" : "R3";
    if (s == 2'd1) rq = {rq, "/R8"};
    else if (s == 2'd2) rq = {rq, "/R7 reserved"};
    else rq = {rq, "/R7"};
    chk({rq, " samp count"}, ns, exp_s);
    chk({rq, " first samp after write R10"}, first, exp_first);
    if (sy) chk("R6 bit count sync", nb, exp_b);
    else if (ov) chk("R5 bit count /8", nb, exp_b);
    else chk("R4 bit count /16", nb, exp_b);
  endtask

  task automatic run_ext(input int d, input logic ov, input logic sy);
    int ns, nb, ratio, exp_b;
    ratio = ov ? 8 : 16;
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    do_write(2'd3, d, ov, sy);
    ns = 0; nb = 0;
    for (int e = 0; e < 40; e++) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        div_wr = 1'b0;
        if (k == 0) ext_clk = (e % 2 == 0);
        #1;
        if (samp_tick) ns++;
        if (bit_tick) nb++;
      end
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      if (samp_tick) ns++;
      if (bit_tick) nb++;
    end
    exp_b = sy ? 20 / d : 20 / (d * ratio);
    chk("R9 ext samp count", ns, 20 / d);
    chk("R9 ext bit count", nb, exp_b);
  endtask

  initial begin
    int hit;
    // reset behaviour
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R11 quiet in reset", int'(samp_tick) + int'(bit_tick), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 quiet first cycle after reset", int'(samp_tick) + int'(bit_tick), 0);

    // sweep
    for (int s = 0; s < 3; s++) begin
      for (int di = 0; di < 5; di++) begin
        for (int m = 0; m < 4; m++) begin
          int dv;
          dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 2 : (di == 3) ? 3 : 5;
          run_cfg(2'(s), dv, m[0], m[1]);
        end
      end
    end

    // external clock source
    run_ext(1, 1'b0, 1'b0);
    run_ext(1, 1'b1, 1'b0);
    run_ext(3, 1'b1, 1'b0);
    run_ext(2, 1'b0, 1'b1);

    // write colliding with a due strobe (D=4, due at cycle 3 after write)
    do_write(2'd0, 4, 1'b0, 1'b0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); div_wr = 1'b0; #1;
    end
    @(negedge clk); div_wr = 1'b1; #1;
    chk("R10 write beats due strobe", int'(samp_tick), 0);
    hit = -1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); div_wr = 1'b0; #1;
      if (samp_tick && hit < 0) hit = j;
    end
    chk("R10 R3 full period after collision", hit, 3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule